// File: doc/BRIEF.md
# SPI EEPROM host access sequencer

This block sits between a local request port and a serial EEPROM on a mode-0 SPI link. A single request names a direction, a start address and a byte count. The block then produces every chip-select frame the memory needs. SCK is derived from the system clock by a parameterised divider, and the block raises a one-cycle completion pulse at the end.

A read becomes one frame: the read opcode, a 16-bit address, then as many received bytes as were asked for. Each received byte is handed to the local side with a valid pulse.

A write is cut at every page boundary into segments of at most one page. Each segment is sent as three parts:

- a one-byte enable frame;
- a program frame that stops exactly after the last data bit;
- a series of one-byte status reads that repeats while the busy bit stays set.

Write data is pulled from the local side one byte at a time through a strobe. If the busy bit never clears, a poll limit ends the request with a timeout flag.

Top module: `spi_eeprom_seq`

## Requirements
- R1: After reset, spi_cs_n is high, spi_sck is low, ready is high, and done and timeout are low.
- R2: Before every write segment, the block sends a frame that holds only the byte 0x06, and it raises spi_cs_n right after that byte's eighth clock.
- R3: A program frame carries 0x02, then the address as 16 bits with the bits above ADDR_W sent as zero, then the data bytes, all MSB first. spi_cs_n rises only at a byte boundary after the last data bit.
- R4: A write request is split so that no program frame carries more than PAGE_BYTES bytes or crosses a page boundary. The bytes land at consecutive addresses from the start address, wrapping at the top of the address space.
- R5: After each program frame, the block repeats a two-byte frame (0x05, then one received status byte) until bit 0 of the status byte reads 0. A write-in-progress memory that reports busy k times therefore sees k+1 status frames per segment.
- R6: A read sends 0x03 and the 16-bit address, then receives len bytes in the same frame. Each byte appears on rd_data together with a one-cycle rd_valid pulse, in address order, and the address wraps from the highest location to 0.
- R7: spi_sck is low whenever spi_cs_n is high. Each high phase of spi_sck lasts HALF_DIV clocks and each low phase at least HALF_DIV clocks. spi_mosi changes only while spi_sck is low, and spi_miso is sampled on the rising edge.
- R8: If POLL_MAX status reads in a row report busy, the request ends with done, timeout is high, and no further frame is sent. The next start clears timeout.
- R9: wr_strobe pulses once for each data byte a write sends, exactly len times per write request. The byte on wr_data is taken in the strobe cycle.
- R10: ready is low from the start pulse until done, and done lasts one cycle. A start pulse while a request is running is ignored.
- R11: A request with len equal to 0 completes with done and never drives spi_cs_n low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request pulse, taken while ready is high |
| wr_req | input | 1 | 1 for a write request, 0 for a read |
| addr | input | ADDR_W | Start byte address |
| len | input | LEN_W | Number of bytes to move |
| ready | output | 1 | High when idle and able to take a request |
| wr_data | input | 8 | Next write byte, taken in the cycle wr_strobe is high |
| wr_strobe | output | 1 | One-cycle pulse per write byte taken |
| rd_data | output | 8 | Received read byte |
| rd_valid | output | 1 | One-cycle pulse per received read byte |
| done | output | 1 | One-cycle pulse at the end of a request |
| timeout | output | 1 | Set when the poll limit ended a write; cleared by the next start |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_sck | output | 1 | Serial clock, idles low |
| spi_mosi | output | 1 | Serial data to the memory |
| spi_miso | input | 1 | Serial data from the memory |

## Verification
The bench builds the block with HALF_DIV = 2, POLL_MAX = 4, ADDR_W = 10, PAGE_BYTES = 16 and LEN_W = 11. A divider of 2 keeps each byte to a few dozen cycles, so multi-segment writes and 20-byte bursts stay short runs. A poll limit of 4 lets a memory model that stays busy drive the timeout path within a handful of status frames. The 10-bit address makes the wrap from location 0x3FF to 0 reachable for both a split write and a burst read.

// File: rtl/spi_eeprom_seq.sv
module spi_eeprom_seq #(
  parameter int HALF_DIV   = 4,
  parameter int ADDR_W     = 10,
  parameter int PAGE_BYTES = 16,
  parameter int LEN_W      = 11,
  parameter int POLL_MAX   = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              wr_req,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LEN_W-1:0]  len,
  output logic              ready,
  input  logic [7:0]        wr_data,
  output logic              wr_strobe,
  output logic [7:0]        rd_data,
  output logic              rd_valid,
  output logic              done,
  output logic              timeout,
  output logic              spi_cs_n,
  output logic              spi_sck,
  output logic              spi_mosi,
  input  logic              spi_miso
);

  localparam int DIV_W  = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam int PG_W   = $clog2(PAGE_BYTES);
  localparam int SEG_W  = PG_W + 1;
  localparam int POLL_W = $clog2(POLL_MAX + 1);
  localparam logic [DIV_W-1:0]  DIV_TOP   = DIV_W'(HALF_DIV - 1);
  localparam logic [POLL_W-1:0] POLL_LAST = POLL_W'(POLL_MAX - 1);

  typedef enum logic [2:0] {S_IDLE, S_LOAD, S_XFER, S_BYTE, S_GAP, S_FIN} state_t;
  typedef enum logic [1:0] {F_WEN, F_PROG, F_STAT, F_FETCH} frame_t;

  state_t              state;
  frame_t              frame;
  logic [1:0]          hdr;
  logic [ADDR_W-1:0]   ptr;
  logic [LEN_W-1:0]    rem;
  logic [SEG_W-1:0]    seg;
  logic [POLL_W-1:0]   poll_cnt;
  logic [7:0]          tx_sr, rx_sr, tx_byte;
  logic [DIV_W-1:0]    div;
  logic [2:0]          bitn;
  logic                sck;
  logic [15:0]         a16;
  logic [SEG_W-1:0]    room, seg_init;

  assign a16      = 16'(ptr);
  assign room     = SEG_W'(PAGE_BYTES) - SEG_W'(ptr[PG_W-1:0]);
  assign seg_init = (LEN_W'(room) > rem) ? SEG_W'(rem) : room;

  assign ready     = (state == S_IDLE);
  assign done      = (state == S_FIN);
  assign spi_cs_n  = !(state == S_LOAD || state == S_XFER || state == S_BYTE);
  assign spi_sck   = sck;
  assign spi_mosi  = tx_sr[7];
  assign wr_strobe = (state == S_LOAD) && (frame == F_PROG) && (hdr == 2'd3);

  always_comb begin
    case (frame)
      F_WEN:   tx_byte = 8'h06;
      F_STAT:  tx_byte = (hdr == 2'd0) ? 8'h05 : 8'h00;
      F_PROG:  case (hdr)
                 2'd0:    tx_byte = 8'h02;
                 2'd1:    tx_byte = a16[15:8];
                 2'd2:    tx_byte = a16[7:0];
                 default: tx_byte = wr_data;
               endcase
      default: case (hdr)
                 2'd0:    tx_byte = 8'h03;
                 2'd1:    tx_byte = a16[15:8];
                 2'd2:    tx_byte = a16[7:0];
                 default: tx_byte = 8'h00;
               endcase
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      frame    <= F_WEN;
      hdr      <= '0;
      ptr      <= '0;
      rem      <= '0;
      seg      <= '0;
      poll_cnt <= '0;
      tx_sr    <= '0;
      rx_sr    <= '0;
      div      <= '0;
      bitn     <= '0;
      sck      <= 1'b0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
      timeout  <= 1'b0;
    end else begin
      rd_valid <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          timeout  <= 1'b0;
          ptr      <= addr;
          rem      <= len;
          hdr      <= '0;
          poll_cnt <= '0;
          frame    <= wr_req ? F_WEN : F_FETCH;
          state    <= (len == '0) ? S_FIN : S_LOAD;
        end
        S_LOAD: begin
          tx_sr <= tx_byte;
          div   <= DIV_TOP;
          bitn  <= '0;
          state <= S_XFER;
        end
        S_XFER: begin
          if (div != '0) begin
            div <= div - DIV_W'(1);
          end else begin
            div <= DIV_TOP;
            sck <= ~sck;
            if (!sck) begin
              rx_sr <= {rx_sr[6:0], spi_miso};
            end else begin
              tx_sr <= {tx_sr[6:0], 1'b0};
              bitn  <= bitn + 3'd1;
              if (bitn == 3'd7) state <= S_BYTE;
            end
          end
        end
        S_BYTE: begin
          case (frame)
            F_WEN: begin
              frame <= F_PROG;
              hdr   <= '0;
              seg   <= seg_init;
              div   <= DIV_TOP;
              state <= S_GAP;
            end
            F_PROG: begin
              if (hdr != 2'd3) begin
                hdr   <= hdr + 2'd1;
                state <= S_LOAD;
              end else begin
                ptr <= ptr + ADDR_W'(1);
                rem <= rem - LEN_W'(1);
                seg <= seg - SEG_W'(1);
                if (seg == SEG_W'(1)) begin
                  frame    <= F_STAT;
                  hdr      <= '0;
                  poll_cnt <= '0;
                  div      <= DIV_TOP;
                  state    <= S_GAP;
                end else begin
                  state <= S_LOAD;
                end
              end
            end
            F_STAT: begin
              if (hdr == 2'd0) begin
                hdr   <= 2'd1;
                state <= S_LOAD;
              end else begin
                hdr <= '0;
                div <= DIV_TOP;
                if (!rx_sr[0]) begin
                  if (rem == '0) begin
                    state <= S_FIN;
                  end else begin
                    frame <= F_WEN;
                    state <= S_GAP;
                  end
                end else if (poll_cnt == POLL_LAST) begin
                  timeout <= 1'b1;
                  state   <= S_FIN;
                end else begin
                  poll_cnt <= poll_cnt + POLL_W'(1);
                  state    <= S_GAP;
                end
              end
            end
            default: begin
              if (hdr != 2'd3) begin
                hdr   <= hdr + 2'd1;
                state <= S_LOAD;
              end else begin
                rd_valid <= 1'b1;
                rd_data  <= rx_sr;
                ptr      <= ptr + ADDR_W'(1);
                rem      <= rem - LEN_W'(1);
                state    <= (rem == LEN_W'(1)) ? S_FIN : S_LOAD;
              end
            end
          endcase
        end
        S_GAP: begin
          if (div != '0) div <= div - DIV_W'(1);
          else           state <= S_LOAD;
        end
        S_FIN:   state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  a_r7_sck_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sck);

  a_r7_mosi_hold: assert property (@(posedge clk) disable iff (!rst_n)
    spi_sck |-> $stable(spi_mosi));

  a_r3_byte_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_cs_n) |-> (bitn == 3'd0));

  a_r5_poll_bound: assert property (@(posedge clk) disable iff (!rst_n)
    poll_cnt < POLL_W'(POLL_MAX));

  a_r4_seg_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (frame == F_PROG && !spi_cs_n) |-> (seg <= SEG_W'(PAGE_BYTES)));

  a_r8_timeout_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout) |-> done);

  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r10_ready_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> spi_cs_n);

endmodule

// File: tb/spi_eeprom_seq_bench.sv
`timescale 1ns/1ps
module spi_eeprom_seq_bench;
  localparam int HALF = 2, POLL = 4, AW = 10, PG = 16, LW = 11;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, wr_req = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [LW-1:0] len = '0;
  logic ready, wr_strobe, rd_valid, done, timeout;
  logic spi_cs_n, spi_sck, spi_mosi;
  logic spi_miso = 1'b0;
  logic [7:0] rd_data, wr_data;
  logic [7:0] wbuf [64];
  int widx = 0, strobes = 0;
  assign wr_data = wbuf[widx];

  spi_eeprom_seq #(.HALF_DIV(HALF), .ADDR_W(AW), .PAGE_BYTES(PG), .LEN_W(LW), .POLL_MAX(POLL)) u_spi_eeprom_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .wr_req(wr_req), .addr(addr), .len(len),
    .ready(ready), .wr_data(wr_data), .wr_strobe(wr_strobe), .rd_data(rd_data),
    .rd_valid(rd_valid), .done(done), .timeout(timeout), .spi_cs_n(spi_cs_n),
    .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso));

  initial forever #2.5 clk = ~clk;

  int checks = 0, errors = 0;
  bit finished = 0;
  task automatic chk(input bit ok, input string msg, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", msg, act, exp);
    end
  endtask

  // memory model on the serial link
  bit [7:0] mem [1024];
  bit [7:0] shadow [1024];
  bit [7:0] m_buf [32];
  bit [7:0] m_op, m_sh, m_ahi, m_out;
  int m_bits = 0, m_nb = 0, m_addr = 0, m_base = 0, m_nd = 0;
  bit wel = 0;
  int busy_left = 0, busy_set = 2;
  int wren_n = 0, write_n = 0, rdsr_n = 0, read_n = 0, cs_falls = 0;
  int wren_err = 0, align_err = 0, page_err = 0, addr_err = 0, nowel_err = 0, sck_err = 0;

  task m_byte(input logic [7:0] b);
    if (m_nb == 0) begin
      m_op = b;
      if (b == 8'h05) begin
        m_out = {7'd0, busy_left != 0};
        if (busy_left > 0) busy_left--;
      end
    end else if (m_nb == 1) begin
      m_ahi = b;
      if ((m_op == 8'h02 || m_op == 8'h03) && b[7:2] != 6'd0) addr_err++;
    end else if (m_nb == 2) begin
      m_addr = {m_ahi[1:0], b};
      m_base = m_addr;
      m_nd = 0;
      if (m_op == 8'h03) begin m_out = mem[m_addr]; m_addr = (m_addr + 1) % 1024; end
    end else if (m_op == 8'h03) begin
      m_out = mem[m_addr];
      m_addr = (m_addr + 1) % 1024;
    end else if (m_op == 8'h02) begin
      if (m_nd < 32) m_buf[m_nd] = b;
      m_nd++;
    end
    m_nb++;
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) begin mem[i] = 8'hFF; shadow[i] = 8'hFF; end
    forever begin
      @(negedge spi_cs_n);
      m_bits = 0; m_nb = 0; m_op = 8'h00; cs_falls++;
    end
  end

  initial forever begin
    @(posedge spi_sck);
    if (!spi_cs_n) begin
      m_sh = {m_sh[6:0], spi_mosi};
      m_bits++;
      if (m_bits % 8 == 0) m_byte(m_sh);
    end
  end

  initial forever begin
    @(negedge spi_sck);
    if (!spi_cs_n) begin
      spi_miso = m_out[7];
      m_out = {m_out[6:0], 1'b0};
    end
  end

  initial forever begin
    @(posedge spi_cs_n);
    if (m_bits != 0) begin
      if (m_op == 8'h06) begin
        wren_n++;
        if (m_bits != 8) wren_err++; else wel = 1;
      end else if (m_op == 8'h02) begin
        write_n++;
        if (!wel) nowel_err++;
        if (m_bits % 8 != 0 || m_nd == 0) align_err++;
        else begin
          if (m_nd > PG || (m_base % PG) + m_nd > PG) page_err++;
          if (wel) begin
            for (int i = 0; i < m_nd && i < 32; i++)
              mem[(m_base / PG) * PG + ((m_base + i) % PG)] = m_buf[i];
            wel = 0;
            busy_left = busy_set;
          end
        end
      end else if (m_op == 8'h05) begin
        rdsr_n++;
        if (m_bits != 16) align_err++;
      end else if (m_op == 8'h03) begin
        read_n++;
      end
    end
  end

  // R7 link timing monitor
  initial begin
    logic p_sck, p_mosi;
    int run;
    p_sck = 1'b0; p_mosi = 1'b0; run = 0;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (spi_cs_n && spi_sck) sck_err++;
        if (spi_sck && p_sck && spi_mosi != p_mosi) sck_err++;
        if (spi_sck == p_sck) run++;
        else begin
          if (p_sck && run != HALF) sck_err++;
          if (!p_sck && run < HALF) sck_err++;
          run = 1;
        end
        p_sck = spi_sck; p_mosi = spi_mosi;
      end
    end
  end

  // write data feed
  initial forever begin
    @(negedge clk);
    if (wr_strobe) begin
      strobes++;
      @(posedge clk);
      #1 widx++;
    end
  end

  // scoreboard
  logic [7:0] exp_q [$];
  initial forever begin
    @(negedge clk);
    if (rd_valid) begin
      if (exp_q.size() == 0) chk(1'b0, "R6 unexpected read byte", rd_data, -1);
      else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        chk(rd_data == e, "R6 read byte", rd_data, e);
      end
    end
  end

  bit last_to;
  task automatic run_op(input bit w, input int a, input int n, input int poke);
    int cyc;
    @(negedge clk);
    wr_req = w; addr = AW'(a); len = LW'(n); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(timeout == 1'b0, "R8 timeout cleared by start", timeout, 0);
    cyc = 0;
    while (!done && cyc < 20000) begin
      chk(ready == 1'b0, "R10 ready low while busy", ready, 0);
      cyc++;
      if (cyc == poke) begin start = 1'b1; wr_req = 1'b0; addr = '0; len = LW'(5); end
      else start = 1'b0;
      @(negedge clk);
    end
    start = 1'b0;
    chk(done == 1'b1, "R10 done reached", done, 1);
    last_to = timeout;
    @(negedge clk);
    chk(done == 1'b0, "R10 done one cycle", done, 0);
    chk(ready == 1'b1, "R10 ready after done", ready, 1);
  endtask

  task automatic do_write(input int a, input int n, input int seed, input int poke);
    for (int i = 0; i < n; i++) begin
      wbuf[i] = 8'(seed + i * 37);
      shadow[(a + i) % 1024] = wbuf[i];
    end
    widx = 0; strobes = 0;
    run_op(1'b1, a, n, poke);
    chk(strobes == n, "R9 strobe count", strobes, n);
  endtask

  task automatic do_read(input int a, input int n);
    for (int i = 0; i < n; i++) exp_q.push_back(shadow[(a + i) % 1024]);
    run_op(1'b0, a, n, -1);
    repeat (2) @(negedge clk);
    chk(exp_q.size() == 0, "R6 all bytes delivered", exp_q.size(), 0);
  endtask

  initial begin
    int w0, p0, s0, r0, c0;
    repeat (4) @(negedge clk);
    chk(spi_cs_n == 1'b1, "R1 cs_n high", spi_cs_n, 1);
    chk(spi_sck == 1'b0, "R1 sck low", spi_sck, 0);
    chk(ready == 1'b1, "R1 ready high", ready, 1);
    chk(done == 1'b0, "R1 done low", done, 0);
    chk(timeout == 1'b0, "R1 timeout low", timeout, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // single byte write with a start poked mid-request (R10 ignore)
    w0 = wren_n; p0 = write_n; s0 = rdsr_n; r0 = read_n;
    do_write(5, 1, 8'hA5, 30);
    chk(wren_n - w0 == 1, "R2 enable frames", wren_n - w0, 1);
    chk(write_n - p0 == 1, "R3 program frames", write_n - p0, 1);
    chk(rdsr_n - s0 == 3, "R5 status frames", rdsr_n - s0, 3);
    chk(read_n - r0 == 0, "R10 start ignored while busy", read_n - r0, 0);
    chk(last_to == 1'b0, "R8 no timeout", last_to, 0);
    do_read(5, 1);

    // page-crossing write: 4 + 16 bytes
    w0 = wren_n; p0 = write_n; s0 = rdsr_n;
    do_write(12'h01C, 20, 8'h11, -1);
    chk(wren_n - w0 == 2, "R4 enable frames per segment", wren_n - w0, 2);
    chk(write_n - p0 == 2, "R4 program frames split", write_n - p0, 2);
    chk(rdsr_n - s0 == 6, "R5 status frames per segment", rdsr_n - s0, 6);
    do_read(12'h01C, 20);

    // write and read across top of address space
    p0 = write_n; r0 = read_n;
    do_write(12'h3FE, 3, 8'h5C, -1);
    chk(write_n - p0 == 2, "R4 wrap split", write_n - p0, 2);
    do_read(12'h3FE, 3);
    chk(read_n - r0 == 1, "R6 single read frame", read_n - r0, 1);

    // busy never clears
    busy_set = 100;
    s0 = rdsr_n; p0 = write_n;
    do_write(12'h100, 1, 8'h3C, -1);
    chk(last_to == 1'b1, "R8 timeout raised", last_to, 1);
    chk(rdsr_n - s0 == POLL, "R8 status frames at limit", rdsr_n - s0, POLL);
    repeat (10) @(negedge clk);
    chk(write_n - p0 == 1 && spi_cs_n == 1'b1, "R8 no frame after timeout", write_n - p0, 1);
    busy_left = 0; busy_set = 2;
    do_read(12'h100, 2);

    // zero length
    c0 = cs_falls;
    run_op(1'b1, 7, 0, -1);
    chk(cs_falls == c0, "R11 no chip select", cs_falls - c0, 0);

    chk(wren_err == 0, "R2 enable frame length", wren_err, 0);
    chk(align_err == 0, "R3 frame byte alignment", align_err, 0);
    chk(addr_err == 0, "R3 upper address bits", addr_err, 0);
    chk(nowel_err == 0, "R2 enable before program", nowel_err, 0);
    chk(page_err == 0, "R4 page limit", page_err, 0);
    chk(sck_err == 0, "R7 clock and data timing", sck_err, 0);

    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule